// File: doc/BRIEF.md
# Periodic Tick and Watchdog Interrupt Generator

This block turns the 32.768 kHz system clock into a periodic time base and a watchdog timeout, and combines them into a single active-low interrupt flag. A prescaler and a binary divider form one counter chain. A 3-bit rate code chooses which stage of the chain acts as the time base, from 1 Hz up to 128 Hz. The watchdog counts completed periods of that time base and times out after four of them, so its timeout is always four periods of the chosen rate.

A command decoder placed in front of the block issues one-cycle strobes that switch the timer, the watchdog and the interrupt on or off and that clear the counters. The rate code is a level input. The output `irq_pull` models an open-drain pad. When it is high, the pad is pulled low, which is the asserted state of the interrupt. When it is low, the pad is released. The block has no data stream, so every pin is plain control or status with no handshake.

Top module: `timebase_watchdog`

## Requirements
- R1: After reset the timer, the watchdog and the interrupt are all disabled, the rate in effect is code 0, and `irq_pull` is 0.
- R2: With the timer and the interrupt enabled and no watchdog flag set, `irq_pull` follows the inverse of the selected chain bit. After a timer clear the output is 1 for the first half period and 0 for the second half. The full period is 2^(PRE_W+STAGES-code) clock cycles.
- R3: Rate code c selects a chain tap. Code 0 is the slowest (1 Hz at PRE_W=8, STAGES=7) and each increment of the code doubles the frequency, up to code 7 (128 Hz).
- R4: A new value on `rate_sel` takes effect only on the edge at which the low PRE_W bits of the chain are all ones (a prescaler rollover). Until that edge the old tap stays in use.
- R5: The timer, watchdog and interrupt enables are independent of each other. Each is set by its own on strobe and cleared by its own off strobe. When both strobes arrive in the same cycle, the off strobe wins.
- R6: While the watchdog is enabled, its 2-bit stage advances once per completed period of the selected time base. The flag sets on the fourth completion, which is a divide-by-4 of the time base.
- R7: Once set, the watchdog flag drives `irq_pull` high whenever the interrupt is enabled, whatever the timer is doing. Only `wdt_clr` or `irq_off` clears the flag.
- R8: `tmr_clr` zeroes the whole chain (prescaler and divider) at the next edge. `wdt_clr` zeroes the watchdog stage and the flag.
- R9: While the interrupt is disabled, `irq_pull` is 0.

## Ports
| Port | Direction | Width | Description |
|------|-----------|-------|-------------|
| clk | input | 1 | System clock (32.768 kHz in use) |
| rst_n | input | 1 | Asynchronous active-low reset |
| rate_sel | input | SEL_W | Time base rate code, 0 = slowest |
| tmr_on | input | 1 | Strobe: enable the time base output |
| tmr_off | input | 1 | Strobe: disable the time base output |
| tmr_clr | input | 1 | Strobe: zero the counter chain |
| wdt_on | input | 1 | Strobe: enable the watchdog |
| wdt_off | input | 1 | Strobe: disable the watchdog |
| wdt_clr | input | 1 | Strobe: zero the watchdog stage and flag |
| irq_on | input | 1 | Strobe: enable the interrupt output |
| irq_off | input | 1 | Strobe: disable the interrupt and drop the flag |
| irq_pull | output | 1 | 1 = pull the open-drain interrupt pad low |

## Verification
The bench builds the block with PRE_W=2 and STAGES=7. This shrinks the slowest period to 512 cycles and the four-period watchdog timeout at code 0 to 2048 cycles. With these values every rate code, rollover-aligned rate changes and repeated watchdog timeouts all fit in a short run. The full tap selection still works with all eight codes and a 3-bit select.

// File: rtl/tbwd_pkg.sv
package tbwd_pkg;

  typedef struct packed {
    logic set;
    logic drop;
  } en_ctl_t;

  function automatic logic next_enable(input logic cur, input en_ctl_t c);
    if (c.drop)     return 1'b0;
    else if (c.set) return 1'b1;
    else            return cur;
  endfunction

endpackage

// File: rtl/tbwd_divider.sv
module tbwd_divider #(
  parameter int PRE_W  = 8,
  parameter int STAGES = 7,
  parameter int SEL_W  = 3,
  localparam int CH_W  = PRE_W + STAGES,
  localparam int NSEL  = 1 << SEL_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             clr,
  input  logic [SEL_W-1:0] rate_sel,
  output logic [CH_W-1:0]  count,
  output logic [SEL_W-1:0] sel_act,
  output logic             pre_roll,
  output logic             tb_level,
  output logic             period_end
);
  localparam logic [CH_W-1:0] ONE = CH_W'(1);

  logic [NSEL-1:0] lvl;
  logic [NSEL-1:0] endv;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)   count <= '0;
    else if (clr) count <= '0;
    else          count <= count + ONE;
  end

  assign pre_roll = &count[PRE_W-1:0];

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)        sel_act <= '0;
    else if (pre_roll) sel_act <= rate_sel;
  end

  for (genvar s = 0; s < NSEL; s++) begin : g_tap
    localparam int TAP = (s <= STAGES) ? (CH_W - 1 - s) : (PRE_W - 1);
    assign lvl[s]  = count[TAP];
    assign endv[s] = &count[TAP:0];
  end

  assign tb_level   = lvl[sel_act];
  assign period_end = endv[sel_act];
endmodule

// File: rtl/tbwd_watchdog.sv
module tbwd_watchdog #(
  parameter int WD_W = 2
) (
  input  logic clk,
  input  logic rst_n,
  input  logic run,
  input  logic tick,
  input  logic cnt_clr,
  input  logic flag_clr,
  output logic flag
);
  localparam logic [WD_W-1:0] ONE = WD_W'(1);

  logic [WD_W-1:0] stage;
  logic            advance;

  assign advance = run & tick;

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)       stage <= '0;
    else if (cnt_clr) stage <= '0;
    else if (advance) stage <= stage + ONE;
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n)                   flag <= 1'b0;
    else if (cnt_clr || flag_clr) flag <= 1'b0;
    else if (advance && (&stage)) flag <= 1'b1;
  end
endmodule

// File: rtl/tbwd_irq_out.sv
module tbwd_irq_out (
  input  logic irq_en,
  input  logic tmr_en,
  input  logic tb_level,
  input  logic flag,
  output logic pull
);
  always_comb begin
    pull = 1'b0;
    if (irq_en) pull = (tmr_en & ~tb_level) | flag;
  end
endmodule

// File: rtl/timebase_watchdog.sv
module timebase_watchdog #(
  parameter int PRE_W  = 8,
  parameter int STAGES = 7,
  parameter int WD_W   = 2,
  localparam int SEL_W = $clog2(STAGES + 1),
  localparam int CH_W  = PRE_W + STAGES
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [SEL_W-1:0] rate_sel,
  input  logic             tmr_on,
  input  logic             tmr_off,
  input  logic             tmr_clr,
  input  logic             wdt_on,
  input  logic             wdt_off,
  input  logic             wdt_clr,
  input  logic             irq_on,
  input  logic             irq_off,
  output logic             irq_pull
);
  import tbwd_pkg::*;

  localparam int N_EN = 3;
  localparam int I_TMR = 0;
  localparam int I_WDT = 1;
  localparam int I_IRQ = 2;

  en_ctl_t            ctl [N_EN];
  logic [N_EN-1:0]    en_q;
  logic [CH_W-1:0]    count;
  logic [SEL_W-1:0]   sel_act;
  logic               pre_roll, tb_level, period_end, flag;

  assign ctl[I_TMR] = '{set: tmr_on, drop: tmr_off};
  assign ctl[I_WDT] = '{set: wdt_on, drop: wdt_off};
  assign ctl[I_IRQ] = '{set: irq_on, drop: irq_off};

  for (genvar i = 0; i < N_EN; i++) begin : g_en
    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) en_q[i] <= 1'b0;
      else        en_q[i] <= next_enable(en_q[i], ctl[i]);
    end
  end

  tbwd_divider #(.PRE_W(PRE_W), .STAGES(STAGES), .SEL_W(SEL_W)) u_div (
    .clk(clk), .rst_n(rst_n), .clr(tmr_clr), .rate_sel(rate_sel),
    .count(count), .sel_act(sel_act), .pre_roll(pre_roll),
    .tb_level(tb_level), .period_end(period_end)
  );

  tbwd_watchdog #(.WD_W(WD_W)) u_wdt (
    .clk(clk), .rst_n(rst_n), .run(en_q[I_WDT]), .tick(period_end),
    .cnt_clr(wdt_clr), .flag_clr(irq_off), .flag(flag)
  );

  tbwd_irq_out u_out (
    .irq_en(en_q[I_IRQ]), .tmr_en(en_q[I_TMR]), .tb_level(tb_level),
    .flag(flag), .pull(irq_pull)
  );
endmodule

// File: rtl/tbwd_checker.sv
module tbwd_checker #(
  parameter int CH_W  = 15,
  parameter int SEL_W = 3
) (
  input logic             clk,
  input logic             rst_n,
  input logic             tmr_clr,
  input logic             wdt_clr,
  input logic             irq_off,
  input logic             irq_pull,
  input logic [CH_W-1:0]  count,
  input logic [SEL_W-1:0] sel_act,
  input logic             pre_roll,
  input logic             period_end,
  input logic             wdt_run,
  input logic             flag
);
  AST_IRQ_OFF_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    irq_off |=> !irq_pull); // R9
  AST_FLAG_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    (flag && !wdt_clr && !irq_off) |=> flag); // R7
  AST_FLAG_DROP: assert property (@(posedge clk) disable iff (!rst_n)
    (wdt_clr || irq_off) |=> !flag); // R7
  AST_FLAG_CAUSE: assert property (@(posedge clk) disable iff (!rst_n)
    $rose(flag) |-> $past(period_end && wdt_run)); // R6
  AST_CHAIN_CLEAR: assert property (@(posedge clk) disable iff (!rst_n)
    tmr_clr |=> (count == '0)); // R8
  AST_RATE_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !pre_roll |=> $stable(sel_act)); // R4
endmodule

bind timebase_watchdog tbwd_checker #(.CH_W(CH_W), .SEL_W(SEL_W)) u_chk (
  .clk(clk), .rst_n(rst_n), .tmr_clr(tmr_clr), .wdt_clr(wdt_clr),
  .irq_off(irq_off), .irq_pull(irq_pull), .count(count), .sel_act(sel_act),
  .pre_roll(pre_roll), .period_end(period_end), .wdt_run(en_q[1]), .flag(flag)
);

// File: tb/timebase_watchdog_tb.sv
`timescale 1ns/1ps
module timebase_watchdog_tb;
  localparam int PRE_W = 2;
  localparam int STAGES = 7;
  localparam int CH_W = PRE_W + STAGES;
  localparam int SEL_W = 3;
  localparam int B_TON = 0, B_TOFF = 1, B_TCLR = 2, B_WON = 3,
                 B_WOFF = 4, B_WCLR = 5, B_ION = 6, B_IOFF = 7;

  logic clk = 1'b0;
  logic rst_n = 1'b0;
  logic [SEL_W-1:0] rate_sel = '0;
  logic [7:0] stb = '0;
  logic irq_pull;
  int n_vec = 0;
  int n_bad = 0;
  bit done = 0;

  always #2.5 clk = ~clk;

  timebase_watchdog #(.PRE_W(PRE_W), .STAGES(STAGES)) u_dut (
    .clk(clk), .rst_n(rst_n), .rate_sel(rate_sel),
    .tmr_on(stb[B_TON]), .tmr_off(stb[B_TOFF]), .tmr_clr(stb[B_TCLR]),
    .wdt_on(stb[B_WON]), .wdt_off(stb[B_WOFF]), .wdt_clr(stb[B_WCLR]),
    .irq_on(stb[B_ION]), .irq_off(stb[B_IOFF]), .irq_pull(irq_pull)
  );

  // Reference state built from the requirements
  logic [CH_W-1:0] m_chain;
  logic [SEL_W-1:0] m_sel;
  logic [1:0] m_stage;
  logic m_flag, m_t, m_w, m_i;

  function automatic int tap(input logic [SEL_W-1:0] s);
    return CH_W - 1 - int'(s);
  endfunction

  function automatic logic period_done(input logic [CH_W-1:0] c, input logic [SEL_W-1:0] s);
    int mk = (2 << tap(s)) - 1;
    return (int'(c) & mk) == mk;
  endfunction

  function automatic logic expect_pull();
    return m_i & ((m_t & ~m_chain[tap(m_sel)]) | m_flag);
  endfunction

  always @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      m_chain <= '0; m_sel <= '0; m_stage <= '0;
      m_flag <= 1'b0; m_t <= 1'b0; m_w <= 1'b0; m_i <= 1'b0;
    end else begin
      m_chain <= stb[B_TCLR] ? '0 : m_chain + 1'b1;
      if (&m_chain[PRE_W-1:0]) m_sel <= rate_sel;
      m_t <= stb[B_TOFF] ? 1'b0 : (stb[B_TON] ? 1'b1 : m_t);
      m_w <= stb[B_WOFF] ? 1'b0 : (stb[B_WON] ? 1'b1 : m_w);
      m_i <= stb[B_IOFF] ? 1'b0 : (stb[B_ION] ? 1'b1 : m_i);
      if (stb[B_WCLR]) begin
        m_stage <= '0; m_flag <= 1'b0;
      end else begin
        if (m_w && period_done(m_chain, m_sel)) begin
          m_stage <= m_stage + 1'b1;
          if (m_stage == 2'd3) m_flag <= 1'b1;
        end
        if (stb[B_IOFF]) m_flag <= 1'b0;
      end
    end
  end

  // Cycle-by-cycle comparison against the reference (R2 R3 R5 R6 R7 R9)
  always @(negedge clk) begin
    if (rst_n && !done) begin
      n_vec++;
      if (irq_pull !== expect_pull()) begin
        n_bad++;
        $display("FAIL R2/R6/R7 model compare: irq_pull=%0b expected=%0b at %0t",
                 irq_pull, expect_pull(), $time);
      end
    end
  end

  task automatic check(input string tag, input logic act, input logic exp);
    n_vec++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0b expected=%0b at %0t", tag, act, exp, $time);
    end
  endtask

  task automatic check_int(input string tag, input int act, input int exp);
    n_vec++;
    if (act != exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0d expected=%0d", tag, act, exp);
    end
  endtask

  task automatic pulse(input logic [7:0] v);
    stb = v;
    @(negedge clk);
    stb = '0;
  endtask

  task automatic wait_n(input int n);
    repeat (n) @(negedge clk);
  endtask

  initial begin
    repeat (100000) @(posedge clk);
    if (!done) begin
      done = 1;
      n_vec++; n_bad++;
      $display("FAIL watchdog: run did not finish");
      $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
      $finish;
    end
  end

  initial begin
    int ones;
    logic first;
    logic mid;
    void'($urandom(32'd1729));
    wait_n(3);
    rst_n = 1'b1;
    wait_n(2);
    check("R1 reset quiet", irq_pull, 1'b0);

    // R2/R8: code 0, clear aligns the chain, first half pulls
    pulse(8'(1 << B_TON | 1 << B_ION | 1 << B_TCLR));
    check("R8 clear then first half", irq_pull, 1'b1);
    ones = 0;
    for (int i = 0; i < 512; i++) begin
      if (i > 0) @(negedge clk);
      if (irq_pull) ones++;
      if (i == 256) mid = irq_pull;
    end
    check_int("R2 code0 low-half cycles", ones, 256);
    check("R2 code0 second half released", mid, 1'b0);

    // R3: code 7 gives a 4-cycle period
    rate_sel = 3'd7;
    wait_n(8);
    pulse(8'(1 << B_TCLR));
    ones = 0;
    for (int i = 0; i < 16; i++) begin
      if (i > 0) @(negedge clk);
      if (irq_pull) ones++;
      if (i == 2) mid = irq_pull;
    end
    check_int("R3 code7 ones in 16", ones, 8);
    check("R3 code7 toggles after 2", mid, 1'b0);

    // R4: rate change waits for prescaler rollover
    pulse(8'(1 << B_TCLR));
    rate_sel = 3'd0;
    wait_n(3);
    check("R4 old tap before rollover", irq_pull, 1'b0);
    wait_n(1);
    check("R4 new tap after rollover", irq_pull, 1'b1);

    // R6/R7: watchdog times out after four periods at code 7
    rate_sel = 3'd7;
    wait_n(8);
    pulse(8'(1 << B_TOFF | 1 << B_TCLR | 1 << B_WCLR | 1 << B_WON));
    wait_n(15);
    check("R6 no flag after 3 periods", irq_pull, 1'b0);
    wait_n(1);
    check("R6 flag on 4th period", irq_pull, 1'b1);
    wait_n(50);
    check("R7 flag sticky", irq_pull, 1'b1);
    pulse(8'(1 << B_WCLR));
    check("R8 wdt clear drops flag", irq_pull, 1'b0);
    wait_n(20);
    check("R6 second timeout", irq_pull, 1'b1);
    pulse(8'(1 << B_IOFF));
    check("R9 irq off releases", irq_pull, 1'b0);
    pulse(8'(1 << B_ION));
    check("R7 flag gone after irq off", irq_pull, 1'b0);
    pulse(8'(1 << B_WOFF));

    // R9: interrupt disabled hides timer
    pulse(8'(1 << B_TON));
    pulse(8'(1 << B_IOFF));
    first = 1'b0;
    for (int i = 0; i < 64; i++) begin
      @(negedge clk);
      first = first | irq_pull;
    end
    check("R9 disabled stays released", first, 1'b0);

    // R5: simultaneous on/off leaves timer off; other enables independent
    pulse(8'(1 << B_ION | 1 << B_TOFF));
    pulse(8'(1 << B_TON | 1 << B_TOFF));
    first = 1'b0;
    for (int i = 0; i < 32; i++) begin
      @(negedge clk);
      first = first | irq_pull;
    end
    check("R5 off wins over on", first, 1'b0);
    pulse(8'(1 << B_TON));
    wait_n(1);
    first = 1'b0;
    for (int i = 0; i < 8; i++) begin
      @(negedge clk);
      first = first | irq_pull;
    end
    check("R5 timer on alone drives", first, 1'b1);

    // Random phase, compared against the reference every cycle
    for (int c = 0; c < 30000; c++) begin
      logic [7:0] v;
      v = '0;
      for (int b = 0; b < 8; b++) begin
        int lim;
        lim = (b == B_TCLR || b == B_WCLR) ? 2500 : 64;
        if ($urandom_range(lim - 1) == 0) v[b] = 1'b1;
      end
      if ($urandom_range(399) == 0) rate_sel = 3'($urandom_range(7));
      stb = v;
      @(negedge clk);
    end
    stb = '0;
    wait_n(2);
    done = 1;
    $display("== %0d vectors applied, %0d miscompares ==", n_vec, n_bad);
    $finish;
  end
endmodule